// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block produces the address stream of a two-dimensional memory transfer. Software programs a base address, a per-row element count with a signed step between elements, and a row count with a signed step applied at each row end. The row-end step replaces the element step, so one register describes either padding at the end of a line or the stride needed to walk a sub-rectangle inside a wider frame. Elements are 16 or 32 bits wide, and a direction flag tells the consumer whether the channel writes to memory or reads from it.

Addresses leave the block one at a time behind a valid/ready handshake. A transfer starts when software sets the enable bit. It stops either when software clears that bit or, in single-pass mode, after the final element of the final row. In looping mode the block returns to the base address after the final element and keeps going with no software action. Sticky completion and fault flags are cleared by writing ones to the status register.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset, `addr_valid`, `busy`, `done` and `error` are all low.
- R2: A configuration write to offset 5 with bit 0 (enable) set, made while enable is clear and the configuration is legal, raises `addr_valid` and `busy` on the same clock edge and presents the base address (offset 0) on `addr_out`.
- R3: Each accepted address (`addr_valid` and `addr_ready` both high at an edge) that is not the last element of its row advances `addr_out` by the sign-extended element step (offset 2). While `addr_ready` is low, `addr_out` holds its value.
- R4: Accepting the last element of a row, where the row length is the count at offset 1, adds the sign-extended row step (offset 4) in place of the element step and starts the next row.
- R5: In single-pass mode (control bit 1 clear), accepting the last element of the last row, where the row count is at offset 3, drops `addr_valid` and `busy`, sets `done` and clears the enable bit.
- R6: In looping mode (control bit 1 set), accepting the last element of the last row sets `done`, returns `addr_out` to the base address and keeps `addr_valid` high.
- R7: A write to offset 5 with bit 0 clear drops `addr_valid` and `busy` on that edge. No further address is offered until enable is set again.
- R8: A write to offset 6 clears `done` where data bit 0 is one and `error` where data bit 1 is one. Zero bits leave the flags unchanged.
- R9: An enable request whose element or row count is zero, or whose base address or either step is misaligned to the element size, sets `error`, leaves enable clear and offers no address. A 16-bit element needs address bit 0 clear. A 32-bit element needs bits 1:0 clear.
- R10: Both steps are 16-bit two's complement values sign-extended to the address width, so negative steps walk downward.
- R11: `elem_wide` follows control bit 2 (set selects 32-bit elements) and `dir_write` follows control bit 3 (set marks a memory-writing channel).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Register offset: 0 base, 1 element count, 2 element step, 3 row count, 4 row step, 5 control, 6 status |
| cfg_wdata | input | ADDR_W (32) | Write data |
| addr_ready | input | 1 | Consumer accepts the current address |
| addr_valid | output | 1 | `addr_out` holds an address to take |
| addr_out | output | ADDR_W (32) | Current element address |
| elem_wide | output | 1 | Element size is 32 bits (otherwise 16) |
| dir_write | output | 1 | Channel writes memory |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Sticky completion flag |
| error | output | 1 | Sticky configuration fault flag |

## Verification
The bench builds the block with its default parameters: a 32-bit address and 16-bit counts and steps. These widths are wide enough for the full-frame sub-rectangle step of 1412 bytes and for negative steps that wrap through the upper address bits. Random frames use element counts of 1 to 6 and row counts of 1 to 4. This keeps single-element rows, single-row frames and back-to-back row ends cheap to reach while the consumer stalls at random. Directed runs cover looping wrap-around, stop during a looping run, clearing a flag with a zero bit versus a one bit, and each fault class.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  // register offsets
  localparam int REG_AW = 3;
  localparam logic [REG_AW-1:0] OFS_BASE = 3'd0;
  localparam logic [REG_AW-1:0] OFS_XCNT = 3'd1;
  localparam logic [REG_AW-1:0] OFS_XMOD = 3'd2;
  localparam logic [REG_AW-1:0] OFS_YCNT = 3'd3;
  localparam logic [REG_AW-1:0] OFS_YMOD = 3'd4;
  localparam logic [REG_AW-1:0] OFS_CTRL = 3'd5;
  localparam logic [REG_AW-1:0] OFS_STAT = 3'd6;
  // control bit positions
  localparam int CB_EN    = 0;
  localparam int CB_LOOP  = 1;
  localparam int CB_WIDE  = 2;
  localparam int CB_WRITE = 3;
  // status bit positions
  localparam int SB_DONE = 0;
  localparam int SB_ERR  = 1;

  typedef struct packed {
    logic en;
    logic loop_mode;
    logic wide;
    logic wr;
  } ctrl_t;
endpackage

// File: rtl/dma2d_regs.sv
module dma2d_regs
  import dma2d_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int MOD_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [REG_AW-1:0] waddr,
  input  logic [ADDR_W-1:0] wdata,
  input  logic              busy,
  input  logic              frame_end,
  output logic [ADDR_W-1:0] base_q,
  output logic [CNT_W-1:0]  xcnt_q,
  output logic [CNT_W-1:0]  ycnt_q,
  output logic [MOD_W-1:0]  xmod_q,
  output logic [MOD_W-1:0]  ymod_q,
  output ctrl_t             ctrl_q,
  output logic              start_ok,
  output logic              start_bad,
  output logic              stop_req,
  output logic [1:0]        stat_clr
);
  logic       wr_ctrl;
  logic       go_req;
  logic [1:0] align_mask;
  logic       misalign;
  logic       zero_cnt;

  assign wr_ctrl    = we && (waddr == OFS_CTRL);
  assign go_req     = wr_ctrl && wdata[CB_EN] && !ctrl_q.en;
  assign align_mask = wdata[CB_WIDE] ? 2'b11 : 2'b01;
  assign misalign   = |((base_q[1:0] | xmod_q[1:0] | ymod_q[1:0]) & align_mask);
  assign zero_cnt   = (xcnt_q == '0) || (ycnt_q == '0);
  assign start_ok   = go_req && !misalign && !zero_cnt;
  assign start_bad  = go_req && (misalign || zero_cnt);
  assign stop_req   = wr_ctrl && !wdata[CB_EN];
  assign stat_clr   = (we && (waddr == OFS_STAT)) ? {wdata[SB_ERR], wdata[SB_DONE]} : 2'b00;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      xcnt_q <= '0;
      ycnt_q <= '0;
      xmod_q <= '0;
      ymod_q <= '0;
    end else if (we) begin
      case (waddr)
        OFS_BASE: base_q <= wdata;
        OFS_XCNT: xcnt_q <= wdata[CNT_W-1:0];
        OFS_XMOD: xmod_q <= wdata[MOD_W-1:0];
        OFS_YCNT: ycnt_q <= wdata[CNT_W-1:0];
        OFS_YMOD: ymod_q <= wdata[MOD_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.loop_mode <= wdata[CB_LOOP];
        ctrl_q.wide      <= wdata[CB_WIDE];
        ctrl_q.wr        <= wdata[CB_WRITE];
      end
      if (frame_end && !ctrl_q.loop_mode)
        ctrl_q.en <= 1'b0;
      else if (wr_ctrl)
        ctrl_q.en <= wdata[CB_EN] && !start_bad;
    end
  end

  // R7: no transfer runs while the enable bit is clear
  assert_idle_when_off_R7: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q.en |-> !busy);
  // R9: a rejected enable request leaves enable clear
  assert_reject_R9: assert property (@(posedge clk) disable iff (rst)
    start_bad |=> !ctrl_q.en);
endmodule

// File: rtl/dma2d_seq.sv
module dma2d_seq #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int MOD_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              stop,
  input  logic              loop_mode,
  input  logic              ready,
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  xcnt,
  input  logic [CNT_W-1:0]  ycnt,
  input  logic [MOD_W-1:0]  xmod,
  input  logic [MOD_W-1:0]  ymod,
  output logic [ADDR_W-1:0] addr_q,
  output logic              run_q,
  output logic              frame_end
);
  localparam int EXT_W = ADDR_W - MOD_W;

  logic [CNT_W-1:0]  x_left;
  logic [CNT_W-1:0]  y_left;
  logic [ADDR_W-1:0] xstep;
  logic [ADDR_W-1:0] ystep;
  logic              acc;
  logic              row_last;

  assign xstep     = {{EXT_W{xmod[MOD_W-1]}}, xmod};
  assign ystep     = {{EXT_W{ymod[MOD_W-1]}}, ymod};
  assign acc       = run_q && ready;
  assign row_last  = (x_left <= 1);
  assign frame_end = acc && row_last && (y_left <= 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      addr_q <= '0;
      x_left <= '0;
      y_left <= '0;
    end else if (start) begin
      run_q  <= 1'b1;
      addr_q <= base;
      x_left <= xcnt;
      y_left <= ycnt;
    end else begin
      if (acc) begin
        if (!row_last) begin
          addr_q <= addr_q + xstep;
          x_left <= x_left - 1'b1;
        end else if (y_left > 1) begin
          addr_q <= addr_q + ystep;
          x_left <= xcnt;
          y_left <= y_left - 1'b1;
        end else if (loop_mode) begin
          addr_q <= base;
          x_left <= xcnt;
          y_left <= ycnt;
        end else begin
          run_q <= 1'b0;
        end
      end
      if (stop) run_q <= 1'b0;
    end
  end

  // R3: stalled address holds
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    run_q && !ready |=> $stable(addr_q));
  // R3: in-row step uses the element step
  assert_xstep_R3: assert property (@(posedge clk) disable iff (rst)
    acc && (x_left > 1) |=> addr_q == $past(addr_q) + $past(xstep));
  // R4: row end uses the row step
  assert_ystep_R4: assert property (@(posedge clk) disable iff (rst)
    acc && row_last && (y_left > 1) |=> addr_q == $past(addr_q) + $past(ystep));
  // R6: looping wrap returns to the base and stays valid unless stopped
  assert_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    frame_end && loop_mode && !stop |=> run_q && (addr_q == $past(base)));
endmodule

// File: rtl/dma2d_status.sv
module dma2d_status (
  input  logic       clk,
  input  logic       rst,
  input  logic       set_done,
  input  logic       set_err,
  input  logic [1:0] clr,
  output logic       done_q,
  output logic       err_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (set_done)    done_q <= 1'b1;
      else if (clr[0]) done_q <= 1'b0;
      if (set_err)     err_q  <= 1'b1;
      else if (clr[1]) err_q  <= 1'b0;
    end
  end

  // R5: frame completion is reported
  assert_done_R5: assert property (@(posedge clk) disable iff (rst)
    set_done |=> done_q);
  // R8: write-one clears the completion flag
  assert_clr_R8: assert property (@(posedge clk) disable iff (rst)
    clr[0] && !set_done |=> !done_q);
  // R9: a rejected start is reported
  assert_err_R9: assert property (@(posedge clk) disable iff (rst)
    set_err |=> err_q);
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
  import dma2d_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int MOD_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              addr_ready,
  output logic              addr_valid,
  output logic [ADDR_W-1:0] addr_out,
  output logic              elem_wide,
  output logic              dir_write,
  output logic              busy,
  output logic              done,
  output logic              error
);
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  xcnt_q;
  logic [CNT_W-1:0]  ycnt_q;
  logic [MOD_W-1:0]  xmod_q;
  logic [MOD_W-1:0]  ymod_q;
  ctrl_t             ctrl_q;
  logic              start_ok;
  logic              start_bad;
  logic              stop_req;
  logic [1:0]        stat_clr;
  logic              run_q;
  logic              frame_end;

  dma2d_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .MOD_W(MOD_W)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .waddr(cfg_addr), .wdata(cfg_wdata),
    .busy(run_q), .frame_end(frame_end),
    .base_q(base_q), .xcnt_q(xcnt_q), .ycnt_q(ycnt_q),
    .xmod_q(xmod_q), .ymod_q(ymod_q), .ctrl_q(ctrl_q),
    .start_ok(start_ok), .start_bad(start_bad), .stop_req(stop_req),
    .stat_clr(stat_clr)
  );

  dma2d_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .MOD_W(MOD_W)) u_seq (
    .clk(clk), .rst(rst), .start(start_ok), .stop(stop_req),
    .loop_mode(ctrl_q.loop_mode), .ready(addr_ready),
    .base(base_q), .xcnt(xcnt_q), .ycnt(ycnt_q), .xmod(xmod_q), .ymod(ymod_q),
    .addr_q(addr_out), .run_q(run_q), .frame_end(frame_end)
  );

  dma2d_status u_status (
    .clk(clk), .rst(rst), .set_done(frame_end), .set_err(start_bad),
    .clr(stat_clr), .done_q(done), .err_q(error)
  );

  assign addr_valid = run_q;
  assign busy       = run_q;
  assign elem_wide  = ctrl_q.wide;
  assign dir_write  = ctrl_q.wr;

  // R2: a good start presents the base address
  assert_start_R2: assert property (@(posedge clk) disable iff (rst)
    start_ok |=> addr_valid && (addr_out == $past(base_q)));
  // R7: a stop request removes the address
  assert_stop_R7: assert property (@(posedge clk) disable iff (rst)
    stop_req |=> !addr_valid);
endmodule

// File: tb/tb_dma2d_addr_gen.sv
module tb_dma2d_addr_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        addr_ready = 1'b0;
  logic        addr_valid, elem_wide, dir_write, busy, done, error;
  logic [31:0] addr_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [31:0] m_base;
  int          m_xc, m_yc;
  logic [15:0] m_xm, m_ym;

  dma2d_addr_gen dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .addr_ready(addr_ready), .addr_valid(addr_valid),
    .addr_out(addr_out), .elem_wide(elem_wide), .dir_write(dir_write),
    .busy(busy), .done(done), .error(error)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk);
    #1 cfg_we = 1'b0;
  endtask

  task automatic setup(logic [31:0] b, int xc, logic [15:0] xm, int yc, logic [15:0] ym);
    m_base = b; m_xc = xc; m_xm = xm; m_yc = yc; m_ym = ym;
    wr(3'd0, b);
    wr(3'd1, 32'(xc));
    wr(3'd2, {16'h0, xm});
    wr(3'd3, 32'(yc));
    wr(3'd4, {16'h0, ym});
  endtask

  function automatic logic [31:0] exp_addr(int i);
    int k = i % (m_xc * m_yc);
    int r = k / m_xc;
    int c = k % m_xc;
    logic [31:0] xs = {{16{m_xm[15]}}, m_xm};
    logic [31:0] ys = {{16{m_ym[15]}}, m_ym};
    return m_base + 32'(r) * (32'(m_xc - 1) * xs + ys) + 32'(c) * xs;
  endfunction

  // Accept n addresses with the given ready percentage, checking each one.
  task automatic drive(int n, int pct, string req);
    int idx = 0;
    while (idx < n) begin
      @(negedge clk);
      chk(req, "valid during run", 32'(addr_valid), 32'd1);
      chk(req, "address", addr_out, exp_addr(idx));
      addr_ready = (($urandom % 100) < pct);
      if (addr_ready && addr_valid) idx++;
    end
    @(negedge clk);
    addr_ready = 1'b0;
  endtask

  task automatic single_end(string req);
    chk(req, "valid after last", 32'(addr_valid), 32'd0);
    chk(req, "busy after last", 32'(busy), 32'd0);
    chk(req, "done after last", 32'(done), 32'd1);
    wr(3'd6, 32'h1);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "valid", 32'(addr_valid), 0);
    chk("R1", "busy", 32'(busy), 0);
    chk("R1", "done", 32'(done), 0);
    chk("R1", "error", 32'(error), 0);

    // R2 R3 R4 R5: 32-bit frame, always ready
    setup(32'h1000, 4, 16'd4, 3, 16'd8);
    wr(3'd5, 32'b0101);
    @(negedge clk);
    chk("R2", "first address", addr_out, 32'h1000);
    chk("R11", "elem_wide", 32'(elem_wide), 1);
    chk("R11", "dir_write", 32'(dir_write), 0);
    drive(12, 100, "R4");
    single_end("R5");
    chk("R8", "done cleared by one", 32'(done), 0);

    // R4 R11: 16-bit sub-rectangle, 10 px of 3 bytes in a 480 px frame
    setup(32'h2000_0000, 15, 16'd2, 4, 16'((480 - 10) * 3 + 2));
    wr(3'd5, 32'b1001);
    @(negedge clk);
    chk("R11", "dir_write", 32'(dir_write), 1);
    chk("R11", "elem_wide", 32'(elem_wide), 0);
    chk("R4", "row 2 start", exp_addr(15), 32'h2000_0000 + 32'd1440);
    drive(60, 70, "R4");
    single_end("R5");

    // R10: negative steps
    setup(32'h0000_8000, 3, 16'hFFFC, 3, 16'hFFF0);
    wr(3'd5, 32'b0101);
    drive(9, 80, "R10");
    chk("R10", "last expected", exp_addr(8), 32'h0000_8000 - 32'd56);
    single_end("R5");

    // R3: random configurations with random stalls
    for (int t = 0; t < 25; t++) begin
      bit wide = 1'($urandom % 2);
      int esz = wide ? 4 : 2;
      setup($urandom & 32'hFFFF_FFFC, 1 + int'($urandom % 6),
            16'((int'($urandom % 9) - 4) * esz), 1 + int'($urandom % 4),
            16'((int'($urandom % 41) - 20) * esz));
      wr(3'd5, {29'd0, wide, 1'b0, 1'b1});
      drive(m_xc * m_yc, 55, "R3");
      single_end("R5");
    end

    // R6 looping mode then R7 stop
    setup(32'h4000, 3, 16'd4, 2, 16'd12);
    wr(3'd5, 32'b0111);
    drive(14, 75, "R6");
    chk("R6", "valid after wrap", 32'(addr_valid), 1);
    chk("R6", "wrapped address", addr_out, exp_addr(14));
    chk("R6", "done on wrap", 32'(done), 1);
    // R8: zero bit leaves done
    wr(3'd6, 32'h2);
    @(negedge clk);
    chk("R8", "done kept by zero bit", 32'(done), 1);
    wr(3'd5, 32'b0110);
    @(negedge clk);
    chk("R7", "valid after stop", 32'(addr_valid), 0);
    chk("R7", "busy after stop", 32'(busy), 0);
    addr_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7", "still idle", 32'(addr_valid), 0);
    addr_ready = 1'b0;
    wr(3'd6, 32'h1);

    // R9: zero count
    setup(32'h5000, 0, 16'd4, 2, 16'd4);
    wr(3'd5, 32'b0101);
    @(negedge clk);
    chk("R9", "error on zero count", 32'(error), 1);
    chk("R9", "no valid on zero count", 32'(addr_valid), 0);
    wr(3'd6, 32'h2);
    @(negedge clk);
    chk("R8", "error cleared", 32'(error), 0);
    // R9: 32-bit misaligned base
    setup(32'h5002, 2, 16'd4, 2, 16'd4);
    wr(3'd5, 32'b0101);
    @(negedge clk);
    chk("R9", "error on misaligned", 32'(error), 1);
    chk("R9", "no valid misaligned", 32'(busy), 0);
    wr(3'd6, 32'h2);
    // R9: same base legal for 16-bit elements
    setup(32'h5002, 2, 16'd4, 2, 16'd4);
    wr(3'd5, 32'b0001);
    @(negedge clk);
    chk("R9", "no error 16-bit", 32'(error), 0);
    drive(4, 100, "R9");
    single_end("R5");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule